// File: doc/BRIEF.md
# Reed-Solomon ECC Register Front End

This block is the register face and sequencing logic of a hardware Reed-Solomon error-correction engine for 512-byte flash sectors. Software programs a control word to start a sector in either encode or decode mode. While the engine is enabled, sector bytes stream in and go on to an attached codec datapath. The codec answers with a single done pulse. On that pulse the block latches nine parity bytes after an encode, or an error count, flags and up to four symbol error reports after a decode. Software reads all of these back through a 32-bit register window. The Reed-Solomon arithmetic itself lies outside the block, on the other side of the codec port.

To encode, software sets the enable, reset and encode bits, streams the sector, waits for the encode-finished flag, clears enable and reads the parity. A sector of all 0xFF bytes produces one fixed parity pattern. The block replaces that pattern with nine 0xFF bytes, so an erased page stays fully erased after a write. To decode, software starts the sector with encode clear, streams the data, writes the nine stored parity bytes one byte lane at a time, and then sets parity-ready. That last write launches the correction. The decode-finished flag then reports the outcome.

Top module: `ecc_regfront`

## Requirements
- R1: After reset every register reads zero. The control word at offset 0x100 stores enable (bit 0), RS mode (bit 2), encode (bit 3) and parity-ready (bit 4) and reads them back. Bit 1, the sector-start bit, always reads 0. The encode bit also drives `cdc_encode`.
- R2: `cdc_valid` follows `data_valid` only while enable is 1. `cdc_byte` carries `data_byte`.
- R3: A control write with bit 0 and bit 1 both set raises `cdc_init` for exactly the one cycle after the write.
- R4: Parity byte k (0..8) sits at byte address 0x108+k, which is word 0x108+4*(k/4), lane k%4. A write changes only the bytes whose byte enable is set. Bits 31:8 of word 0x110 read 0.
- R5: A codec done pulse while enable=1 and encode=1 loads parity byte k from `cdc_parity_in[8k+7:8k]` and sets status bit 2.
- R6: If that encoded parity equals bytes 0..8 = CD 9D 90 58 F4 8B FF B7 6F, all nine parity bytes become 0xFF.
- R7: A control write with enable=1, encode=0 and parity-ready=1, made while parity-ready was 0, raises `cdc_par_go` for exactly the next cycle. `cdc_par_out` presents the nine stored parity bytes in the same byte order as R5.
- R8: A done pulse while enable=1 and encode=0 sets status bit 3 and ORs `cdc_uncor` into bit 1. It ORs (uncorrectable or count non-zero) into bit 0 and writes `cdc_err_cnt` into bits 31:29.
- R9: On that decode done, error report i (address 0x11C+4i, i<4) takes the 9-bit symbol index in bits 24:16 and the 9-bit mask in bits 8:0 when i < count. Otherwise the report becomes zero.
- R10: Any write to the status word at 0x114 clears it. A done pulse in the same cycle then sets its own bits on top of the cleared word.
- R11: A done pulse while enable=0 changes no parity byte, status bit or error report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Word-aligned byte address of the register |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| data_valid | input | 1 | Sector byte strobe |
| data_byte | input | 8 | Sector byte |
| cdc_valid | output | 1 | Sector byte strobe to the codec |
| cdc_byte | output | 8 | Sector byte to the codec |
| cdc_init | output | 1 | One-cycle sector start to the codec |
| cdc_encode | output | 1 | Codec mode: 1 encode, 0 decode |
| cdc_par_go | output | 1 | One-cycle start of decode correction |
| cdc_par_out | output | 72 | Stored parity bytes to the codec |
| cdc_done | input | 1 | Codec finish pulse |
| cdc_parity_in | input | 72 | Encoded parity from the codec |
| cdc_err_cnt | input | 3 | Number of corrected symbols |
| cdc_uncor | input | 1 | Sector uncorrectable |
| cdc_err_idx | input | 36 | Four 9-bit one-based symbol indices |
| cdc_err_mask | input | 36 | Four 9-bit error masks |

## Verification
The assertions assume a codec that raises `cdc_done` for single cycles only and never reports more than four errors. They also assume that writes to the parity words while enable=0 are the only thing that moves the parity during readout. The stimulus keeps the error count at 0, 1 or 2 and drives every done pulse for one cycle. It changes parity only by byte writes or encode completions. A behavioural model with per-byte arrays predicts every output and the addressed register on each clock, and directed reads pin the corner cases to literal values. Those corner cases are the erased-sector pattern, partial byte enables, a disabled done and a clear that coincides with a done.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;
  localparam int RF_AW   = 9;
  localparam int RF_DW   = 32;
  localparam int RF_NPAR = 9;
  localparam int RF_NERR = 4;
  localparam int RF_SYMW = 9;
  localparam int RF_CNTW = 3;

  // register offsets inside the block window
  localparam logic [RF_AW-1:0] OFS_CTRL = 9'h100;
  localparam logic [RF_AW-1:0] OFS_PAR0 = 9'h108;
  localparam logic [RF_AW-1:0] OFS_STAT = 9'h114;
  localparam logic [RF_AW-1:0] OFS_ERR0 = 9'h11C;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_INIT = 1;
  localparam int CB_RS   = 2;
  localparam int CB_ENC  = 3;
  localparam int CB_RDY  = 4;

  // status bit positions
  localparam int SB_ERR  = 0;
  localparam int SB_UNC  = 1;
  localparam int SB_ENCF = 2;
  localparam int SB_DECF = 3;
  localparam int SB_CNT  = 29;

  // parity of an all-0xFF sector, byte 0 in the low bits
  localparam logic [71:0] ERASED_PAR = 72'h6FB7FF8BF458909DCD;

  typedef struct packed {
    logic rdy;
    logic enc;
    logic rs;
    logic en;
  } ecc_ctrl_t;
endpackage

// File: rtl/ecc_rf_ctrl.sv
module ecc_rf_ctrl
  import ecc_rf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctrl,
  input  logic [4:0] wr_bits,
  output ecc_ctrl_t ctrl_q,
  output logic      init_q,
  output logic      go_q
);
  ecc_ctrl_t ctrl_d;
  logic      init_d;
  logic      go_d;

  always_comb begin
    ctrl_d = ctrl_q;
    init_d = 1'b0;
    go_d   = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.en  = wr_bits[CB_EN];
      ctrl_d.rs  = wr_bits[CB_RS];
      ctrl_d.enc = wr_bits[CB_ENC];
      ctrl_d.rdy = wr_bits[CB_RDY];
      init_d     = wr_bits[CB_EN] & wr_bits[CB_INIT];
      go_d       = wr_bits[CB_EN] & wr_bits[CB_RDY] & ~wr_bits[CB_ENC] & ~ctrl_q.rdy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      init_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      init_q <= init_d;
      go_q   <= go_d;
    end
  end
endmodule

// File: rtl/ecc_rf_parity.sv
module ecc_rf_parity #(
  parameter int NPAR = 9,
  parameter logic [8*NPAR-1:0] ERASED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAR-1:0]   bwe,
  input  logic [8*NPAR-1:0] bdat,
  input  logic              load,
  input  logic [8*NPAR-1:0] load_val,
  output logic [8*NPAR-1:0] par_q
);
  localparam int PW = 8*NPAR;

  logic [PW-1:0] fill;
  logic [7:0]    pb_q [NPAR];

  assign fill = (load_val == ERASED) ? {PW{1'b1}} : load_val;

  for (genvar k = 0; k < NPAR; k++) begin : g_byte
    logic       b_we;
    logic [7:0] b_d;
    assign b_we = load | bwe[k];
    assign b_d  = load ? fill[8*k +: 8] : bdat[8*k +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pb_q[k] <= 8'h00;
      else if (b_we) pb_q[k] <= b_d;
    end

    assign par_q[8*k +: 8] = pb_q[k];
  end
endmodule

// File: rtl/ecc_rf_status.sv
module ecc_rf_status
  import ecc_rf_pkg::*;
#(
  parameter int NERR = 4,
  parameter int SYMW = 9,
  parameter int CNTW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 done_enc,
  input  logic                 done_dec,
  input  logic [CNTW-1:0]      cnt_in,
  input  logic                 uncor_in,
  input  logic [NERR*SYMW-1:0] idx_in,
  input  logic [NERR*SYMW-1:0] mask_in,
  output logic [RF_DW-1:0]     stat_word,
  output logic [NERR*SYMW-1:0] idx_q,
  output logic [NERR*SYMW-1:0] mask_q
);
  logic            f_err_q, f_unc_q, f_encf_q, f_decf_q;
  logic            f_err_d, f_unc_d, f_encf_d, f_decf_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            stat_upd;

  assign stat_upd = clr | done_enc | done_dec;

  always_comb begin
    f_err_d  = clr ? 1'b0 : f_err_q;
    f_unc_d  = clr ? 1'b0 : f_unc_q;
    f_encf_d = clr ? 1'b0 : f_encf_q;
    f_decf_d = clr ? 1'b0 : f_decf_q;
    cnt_d    = clr ? '0   : cnt_q;
    if (done_enc) f_encf_d = 1'b1;
    if (done_dec) begin
      f_decf_d = 1'b1;
      f_unc_d  = f_unc_d | uncor_in;
      f_err_d  = f_err_d | uncor_in | (cnt_in != '0);
      cnt_d    = cnt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_err_q  <= 1'b0;
      f_unc_q  <= 1'b0;
      f_encf_q <= 1'b0;
      f_decf_q <= 1'b0;
      cnt_q    <= '0;
    end else if (stat_upd) begin
      f_err_q  <= f_err_d;
      f_unc_q  <= f_unc_d;
      f_encf_q <= f_encf_d;
      f_decf_q <= f_decf_d;
      cnt_q    <= cnt_d;
    end
  end

  always_comb begin
    stat_word              = '0;
    stat_word[SB_ERR]      = f_err_q;
    stat_word[SB_UNC]      = f_unc_q;
    stat_word[SB_ENCF]     = f_encf_q;
    stat_word[SB_DECF]     = f_decf_q;
    stat_word[SB_CNT +: CNTW] = cnt_q;
  end

  for (genvar i = 0; i < NERR; i++) begin : g_rep
    logic            live;
    logic [SYMW-1:0] rep_idx_q, rep_mask_q;
    assign live = (int'(cnt_in) > i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rep_idx_q  <= '0;
        rep_mask_q <= '0;
      end else if (done_dec) begin
        rep_idx_q  <= live ? idx_in[SYMW*i +: SYMW]  : '0;
        rep_mask_q <= live ? mask_in[SYMW*i +: SYMW] : '0;
      end
    end

    assign idx_q[SYMW*i +: SYMW]  = rep_idx_q;
    assign mask_q[SYMW*i +: SYMW] = rep_mask_q;
  end
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
  import ecc_rf_pkg::*;
#(
  parameter int NPAR = RF_NPAR,
  parameter int NERR = RF_NERR,
  parameter int SYMW = RF_SYMW,
  parameter int CNTW = RF_CNTW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [RF_AW-1:0]     bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [RF_DW-1:0]     bus_wdata,
  output logic [RF_DW-1:0]     bus_rdata,
  input  logic                 data_valid,
  input  logic [7:0]           data_byte,
  output logic                 cdc_valid,
  output logic [7:0]           cdc_byte,
  output logic                 cdc_init,
  output logic                 cdc_encode,
  output logic                 cdc_par_go,
  output logic [8*NPAR-1:0]    cdc_par_out,
  input  logic                 cdc_done,
  input  logic [8*NPAR-1:0]    cdc_parity_in,
  input  logic [CNTW-1:0]      cdc_err_cnt,
  input  logic                 cdc_uncor,
  input  logic [NERR*SYMW-1:0] cdc_err_idx,
  input  logic [NERR*SYMW-1:0] cdc_err_mask
);
  localparam int PW = 8*NPAR;

  ecc_ctrl_t             ctrl_q;
  logic                  ctl_en, ctl_enc;
  logic                  wr_ctrl, wr_stat;
  logic                  done_enc, done_dec;
  logic [NPAR-1:0]       par_bwe;
  logic [PW-1:0]         par_bdat;
  logic [PW-1:0]         par_q;
  logic [RF_DW-1:0]      stat_word;
  logic [NERR*SYMW-1:0]  rep_idx, rep_mask;

  assign wr_ctrl  = bus_wr & (bus_addr == OFS_CTRL) & bus_be[0];
  assign wr_stat  = bus_wr & (bus_addr == OFS_STAT);
  assign ctl_en   = ctrl_q.en;
  assign ctl_enc  = ctrl_q.enc;
  assign done_enc = cdc_done & ctl_en & ctl_enc;
  assign done_dec = cdc_done & ctl_en & ~ctl_enc;

  for (genvar k = 0; k < NPAR; k++) begin : g_lane
    assign par_bwe[k] = bus_wr & bus_be[k%4] &
                        (bus_addr == OFS_PAR0 + RF_AW'(4*(k/4)));
    assign par_bdat[8*k +: 8] = bus_wdata[8*(k%4) +: 8];
  end

  ecc_rf_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_bits (bus_wdata[4:0]),
    .ctrl_q  (ctrl_q),
    .init_q  (cdc_init),
    .go_q    (cdc_par_go)
  );

  ecc_rf_parity #(
    .NPAR   (NPAR),
    .ERASED ((8*NPAR)'(ERASED_PAR))
  ) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .bwe      (par_bwe),
    .bdat     (par_bdat),
    .load     (done_enc),
    .load_val (cdc_parity_in),
    .par_q    (par_q)
  );

  ecc_rf_status #(
    .NERR (NERR),
    .SYMW (SYMW),
    .CNTW (CNTW)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (wr_stat),
    .done_enc  (done_enc),
    .done_dec  (done_dec),
    .cnt_in    (cdc_err_cnt),
    .uncor_in  (cdc_uncor),
    .idx_in    (cdc_err_idx),
    .mask_in   (cdc_err_mask),
    .stat_word (stat_word),
    .idx_q     (rep_idx),
    .mask_q    (rep_mask)
  );

  assign cdc_valid   = data_valid & ctl_en;
  assign cdc_byte    = data_byte;
  assign cdc_encode  = ctl_enc;
  assign cdc_par_out = par_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL) begin
      bus_rdata[CB_EN]  = ctrl_q.en;
      bus_rdata[CB_RS]  = ctrl_q.rs;
      bus_rdata[CB_ENC] = ctrl_q.enc;
      bus_rdata[CB_RDY] = ctrl_q.rdy;
    end
    if (bus_addr == OFS_STAT) bus_rdata = stat_word;
    for (int k = 0; k < NPAR; k++) begin
      if (bus_addr == OFS_PAR0 + RF_AW'(4*(k/4)))
        bus_rdata[8*(k%4) +: 8] = par_q[8*k +: 8];
    end
    for (int i = 0; i < NERR; i++) begin
      if (bus_addr == OFS_ERR0 + RF_AW'(4*i)) begin
        bus_rdata[16 +: SYMW] = rep_idx[SYMW*i +: SYMW];
        bus_rdata[0  +: SYMW] = rep_mask[SYMW*i +: SYMW];
      end
    end
  end
endmodule

// File: rtl/ecc_regfront_chk.sv
module ecc_regfront_chk
  import ecc_rf_pkg::*;
#(
  parameter int NPAR = RF_NPAR
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [RF_AW-1:0]  bus_addr,
  input logic              data_valid,
  input logic              cdc_valid,
  input logic              cdc_init,
  input logic              cdc_par_go,
  input logic              cdc_done,
  input logic [8*NPAR-1:0] cdc_parity_in,
  input logic [8*NPAR-1:0] cdc_par_out,
  input logic              en,
  input logic              enc
);
  logic par_hit;
  assign par_hit = bus_wr && (bus_addr >= OFS_PAR0) && (bus_addr < OFS_STAT);

  AST_STREAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_valid |-> (data_valid && en)); // R2

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_init |=> !cdc_init); // R3

  AST_ERASED_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_done && en && enc && cdc_parity_in == (8*NPAR)'(ERASED_PAR)) |=> (&cdc_par_out)); // R6

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_par_go |=> !cdc_par_go); // R7

  AST_GO_IN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_par_go |-> (en && !enc)); // R7

  AST_PARITY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !par_hit) |=> $stable(cdc_par_out)); // R11
endmodule

bind ecc_regfront ecc_regfront_chk #(.NPAR(NPAR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .data_valid    (data_valid),
  .cdc_valid     (cdc_valid),
  .cdc_init      (cdc_init),
  .cdc_par_go    (cdc_par_go),
  .cdc_done      (cdc_done),
  .cdc_parity_in (cdc_parity_in),
  .cdc_par_out   (cdc_par_out),
  .en            (ctl_en),
  .enc           (ctl_enc)
);

// File: tb/ecc_regfront_tb.sv
`timescale 1ns/1ps
module ecc_regfront_tb;
  localparam int A_CTRL = 'h100;
  localparam int A_PAR0 = 'h108;
  localparam int A_STAT = 'h114;
  localparam int A_ERR0 = 'h11C;
  localparam logic [71:0] ERASED = 72'h6FB7FF8BF458909DCD;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = 9'h100;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        data_valid = 1'b0;
  logic [7:0]  data_byte = 8'h00;
  logic        cdc_valid, cdc_init, cdc_encode, cdc_par_go;
  logic [7:0]  cdc_byte;
  logic [71:0] cdc_par_out;
  logic        cdc_done = 1'b0;
  logic [71:0] cdc_parity_in = '0;
  logic [2:0]  cdc_err_cnt = '0;
  logic        cdc_uncor = 1'b0;
  logic [35:0] cdc_err_idx = '0;
  logic [35:0] cdc_err_mask = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ecc_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_valid(data_valid), .data_byte(data_byte),
    .cdc_valid(cdc_valid), .cdc_byte(cdc_byte), .cdc_init(cdc_init),
    .cdc_encode(cdc_encode), .cdc_par_go(cdc_par_go), .cdc_par_out(cdc_par_out),
    .cdc_done(cdc_done), .cdc_parity_in(cdc_parity_in), .cdc_err_cnt(cdc_err_cnt),
    .cdc_uncor(cdc_uncor), .cdc_err_idx(cdc_err_idx), .cdc_err_mask(cdc_err_mask)
  );

  // behavioural reference state
  logic       m_en, m_rs, m_enc, m_rdy, m_init, m_go;
  logic [7:0] m_par [9];
  logic       m_ferr, m_func, m_fencf, m_fdecf;
  int         m_cnt;
  int         m_idx [4];
  int         m_mask [4];
  bit         de, dd, cw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rs = 0; m_enc = 0; m_rdy = 0; m_init = 0; m_go = 0;
      for (int k = 0; k < 9; k++) m_par[k] = 8'h00;
      m_ferr = 0; m_func = 0; m_fencf = 0; m_fdecf = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_idx[i] = 0; m_mask[i] = 0; end
    end else begin
      de = cdc_done && m_en && m_enc;
      dd = cdc_done && m_en && !m_enc;
      cw = bus_wr && bus_addr == A_CTRL && bus_be[0];
      m_init = cw && bus_wdata[0] && bus_wdata[1];
      m_go   = cw && bus_wdata[0] && bus_wdata[4] && !bus_wdata[3] && !m_rdy;
      for (int k = 0; k < 9; k++)
        if (bus_wr && bus_addr == A_PAR0 + 4*(k/4) && bus_be[k%4])
          m_par[k] = bus_wdata[8*(k%4) +: 8];
      if (de) begin
        for (int k = 0; k < 9; k++)
          m_par[k] = (cdc_parity_in == ERASED) ? 8'hFF : cdc_parity_in[8*k +: 8];
      end
      if (bus_wr && bus_addr == A_STAT) begin
        m_ferr = 0; m_func = 0; m_fencf = 0; m_fdecf = 0; m_cnt = 0;
      end
      if (de) m_fencf = 1;
      if (dd) begin
        m_fdecf = 1;
        if (cdc_uncor) m_func = 1;
        if (cdc_uncor || cdc_err_cnt != 0) m_ferr = 1;
        m_cnt = cdc_err_cnt;
        for (int i = 0; i < 4; i++) begin
          m_idx[i]  = (i < cdc_err_cnt) ? cdc_err_idx[9*i +: 9]  : 0;
          m_mask[i] = (i < cdc_err_cnt) ? cdc_err_mask[9*i +: 9] : 0;
        end
      end
      if (cw) begin
        m_en = bus_wdata[0]; m_rs = bus_wdata[2]; m_enc = bus_wdata[3]; m_rdy = bus_wdata[4];
      end
    end
  end

  function automatic logic [31:0] model_rd(input int a);
    logic [31:0] r;
    r = '0;
    if (a == A_CTRL) r = {27'd0, m_rdy, m_enc, m_rs, 1'b0, m_en};
    if (a == A_STAT) r = {m_cnt[2:0], 25'd0, m_fdecf, m_fencf, m_func, m_ferr};
    for (int k = 0; k < 9; k++)
      if (a == A_PAR0 + 4*(k/4)) r[8*(k%4) +: 8] = m_par[k];
    for (int i = 0; i < 4; i++)
      if (a == A_ERR0 + 4*i) r = (m_idx[i] << 16) | m_mask[i];
    return r;
  endfunction

  function automatic string rd_tag(input int a);
    if (a == A_CTRL) return "R1";
    if (a == A_STAT) return "R8";
    if (a >= A_PAR0 && a < A_STAT) return "R4";
    return "R9";
  endfunction

  task automatic check(input string tag, input string what, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [71:0] mp;
      for (int k = 0; k < 9; k++) mp[8*k +: 8] = m_par[k];
      check("R2", "cdc_valid", 72'(cdc_valid), 72'(data_valid && m_en));
      if (cdc_valid) check("R2", "cdc_byte", 72'(cdc_byte), 72'(data_byte));
      check("R1", "cdc_encode", 72'(cdc_encode), 72'(m_enc));
      check("R3", "cdc_init", 72'(cdc_init), 72'(m_init));
      check("R7", "cdc_par_go", 72'(cdc_par_go), 72'(m_go));
      check("R7", "cdc_par_out", cdc_par_out, mp);
      check(rd_tag(int'(bus_addr)), "bus_rdata", 72'(bus_rdata), 72'(model_rd(int'(bus_addr))));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    bus_wr = 1; bus_addr = 9'(a); bus_be = be; bus_wdata = d;
    tick();
    bus_wr = 0; bus_be = 4'h0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    bus_addr = 9'(a);
    @(negedge clk);
    check(tag, "directed read", 72'(bus_rdata), 72'(exp));
    tick();
  endtask

  task automatic done_enc(input logic [71:0] p);
    cdc_done = 1; cdc_parity_in = p;
    tick();
    cdc_done = 0;
  endtask

  task automatic done_dec(input int cnt, input logic unc, input logic [35:0] idx, input logic [35:0] msk);
    cdc_done = 1; cdc_err_cnt = 3'(cnt); cdc_uncor = unc; cdc_err_idx = idx; cdc_err_mask = msk;
    tick();
    cdc_done = 0; cdc_uncor = 0;
  endtask

  task automatic stream(input int n, input logic [7:0] seed);
    for (int b = 0; b < n; b++) begin
      data_valid = 1; data_byte = seed + 8'(b);
      tick();
    end
    data_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1: reset values
    rd_chk(A_CTRL, 32'h0, "R1");
    rd_chk(A_STAT, 32'h0, "R8");
    rd_chk(A_PAR0, 32'h0, "R4");
    stream(3, 8'h10);                  // R2: disabled, no forwarding

    // encode sector
    wr(A_CTRL, 4'h1, 32'h0F);          // R3: start pulse
    rd_chk(A_CTRL, 32'h0D, "R1");
    stream(6, 8'h40);                  // R2
    done_enc(72'h998877665544332211);
    rd_chk(A_STAT, 32'h4, "R5");
    rd_chk(A_PAR0,     32'h44332211, "R5");
    rd_chk(A_PAR0 + 4, 32'h88776655, "R5");
    rd_chk(A_PAR0 + 8, 32'h00000099, "R5");
    wr(A_STAT, 4'hF, 32'h0);
    rd_chk(A_STAT, 32'h0, "R10");

    // erased sector
    wr(A_CTRL, 4'h1, 32'h0F);
    stream(4, 8'hFF);
    done_enc(ERASED);
    rd_chk(A_PAR0,     32'hFFFFFFFF, "R6");
    rd_chk(A_PAR0 + 4, 32'hFFFFFFFF, "R6");
    rd_chk(A_PAR0 + 8, 32'h000000FF, "R6");

    // disabled done is ignored
    wr(A_CTRL, 4'h1, 32'h0C);
    stream(2, 8'h77);                  // R2
    done_enc(72'h123456789ABCDEF012);
    done_dec(1, 1'b1, 36'h1, 36'h1);
    rd_chk(A_PAR0, 32'hFFFFFFFF, "R11");
    rd_chk(A_STAT, 32'h4, "R11");
    rd_chk(A_ERR0, 32'h0, "R11");

    // decode with two corrected symbols
    wr(A_STAT, 4'hF, 32'h0);
    wr(A_CTRL, 4'h1, 32'h07);
    rd_chk(A_CTRL, 32'h05, "R1");
    stream(5, 8'h20);
    wr(A_PAR0, 4'b0101, 32'hAABBCCDD);
    rd_chk(A_PAR0, 32'hFFBBFFDD, "R4");
    wr(A_PAR0 + 8, 4'h1, 32'h12345677);
    rd_chk(A_PAR0 + 8, 32'h00000077, "R4");
    wr(A_CTRL, 4'h1, 32'h15);          // R7: go pulse
    wr(A_CTRL, 4'h1, 32'h15);          // R7: no second pulse
    rd_chk(A_CTRL, 32'h15, "R1");
    done_dec(2, 1'b0, {9'd0, 9'd0, 9'd300, 9'd5}, {9'd0, 9'd0, 9'h1A5, 9'h003});
    rd_chk(A_STAT, 32'h40000009, "R8");
    rd_chk(A_ERR0,      32'h00050003, "R9");
    rd_chk(A_ERR0 + 4,  32'h012C01A5, "R9");
    rd_chk(A_ERR0 + 8,  32'h0, "R9");
    rd_chk(A_ERR0 + 12, 32'h0, "R9");

    // uncorrectable sector
    wr(A_STAT, 4'hF, 32'h0);
    wr(A_CTRL, 4'h1, 32'h07);
    wr(A_CTRL, 4'h1, 32'h15);
    done_dec(0, 1'b1, 36'h3FFFF, 36'h3FFFF);
    rd_chk(A_STAT, 32'h0000000B, "R8");
    rd_chk(A_ERR0, 32'h0, "R9");

    // clear and done in the same cycle
    bus_wr = 1; bus_addr = 9'(A_STAT); bus_be = 4'hF; bus_wdata = 32'h0;
    cdc_done = 1; cdc_err_cnt = 3'd1; cdc_uncor = 0;
    cdc_err_idx = 36'h1; cdc_err_mask = 36'h1FF;
    tick();
    bus_wr = 0; cdc_done = 0;
    rd_chk(A_STAT, 32'h20000009, "R10");
    rd_chk(A_ERR0, 32'h000101FF, "R9");
    repeat (3) tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule